// File: doc/BRIEF.md
# General-Purpose I/O Bank with Atomic Drive Control

This block is one bank of 32 general-purpose pins sitting behind a small memory-mapped register port. Software writes a per-pin output value and a per-pin drive enable, and it reads back the pad levels through an input register. The drive-enable register can be rewritten whole. It also has two write-only companion addresses that set or clear chosen bits in a single write. With these, independent software agents can turn drivers on and off without a read-modify-write race.

A per-pin sample enable decides whether the pad level of a pin is captured. Captured levels cross into the bank clock domain through a two-stage synchroniser. Bits that are not enabled read as zero. A pin whose drive enable and sample enable are both zero is released: the bank neither drives it nor samples it, and another function may use the pad. Register selection is an enumerated decode of the bus address, with the selectors `SEL_NONE`, `SEL_IN`, `SEL_OUT`, `SEL_DRV`, `SEL_SMP`, `SEL_DSET` and `SEL_DCLR`. Each selector is handled in a `unique case`. The bank has no sequencing state of its own.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the output-value, drive-enable and sample-enable registers are all zero, so `pad_oe` and `pad_out` are zero and every readable register returns zero.
- R2: The output-value register at byte address 0x0C is read/write. `pad_out[i]` equals its bit i when drive-enable bit i is 1, and is 0 otherwise.
- R3: The drive-enable register at byte address 0x10 is read/write. A plain write replaces all 32 bits, and `pad_oe` follows the register from the clock edge that performs the write.
- R4: A write to byte address 0x70 sets every drive-enable bit whose write-data bit is 1 and leaves the other bits unchanged. A read issued in the cycle after the write returns the new value.
- R5: A write to byte address 0x74 clears every drive-enable bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: The sample-enable register at byte address 0x58 is read/write. The input register at byte address 0x04 shows `pad_in[i]` for each enabled pin. A pad level that is stable from some clock edge onward is visible there after two further edges.
- R7: An input-register bit reads 0 whenever its sample-enable bit is 0. This holds in the first cycle after the enable is cleared.
- R8: Reads of 0x70, 0x74 and any address other than 0x04, 0x0C, 0x10 and 0x58 return zero. Writes to 0x04 or to any unmapped address change no register.
- R9: `bus_rdata` is registered. It carries the data of a read one cycle after `bus_rd`, and it holds its value in cycles without a read. A read issued in the same cycle as a write returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| pad_in | input | 32 | Pad levels, asynchronous to clk |
| pad_out | output | 32 | Value driven toward each pad |
| pad_oe | output | 32 | Per-pad driver enable |

## Verification
The hardest case to reach from the ports is the gap between the synchroniser and the register read. Clearing a sample enable must blank the input bit in the very next read, even though the synchroniser still holds a captured 1. To get there, the stimulus holds every pad high with all pins enabled and lets the chain fill. It then clears part of the enable mask and reads the input register in the next cycle. A full sweep over all 64 word addresses, with set and clear walks over each of the 32 pins, covers the alias decoding and the ignored writes.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int OFS_IN   = 'h04;
    localparam int OFS_OUT  = 'h0C;
    localparam int OFS_DRV  = 'h10;
    localparam int OFS_SMP  = 'h58;
    localparam int OFS_DSET = 'h70;
    localparam int OFS_DCLR = 'h74;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_IN   = 3'd1,
        SEL_OUT  = 3'd2,
        SEL_DRV  = 3'd3,
        SEL_SMP  = 3'd4,
        SEL_DSET = 3'd5,
        SEL_DCLR = 3'd6
    } reg_sel_e;

endpackage

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] out_q,
    output logic [NPINS-1:0] drv_q,
    output logic [NPINS-1:0] smp_q
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic out_nx, drv_nx, smp_nx;

        always_comb begin
            out_nx = out_q[i];
            drv_nx = drv_q[i];
            smp_nx = smp_q[i];
            if (wr_en) begin
                unique case (sel)
                    SEL_OUT:  out_nx = wdata[i];
                    SEL_DRV:  drv_nx = wdata[i];
                    SEL_SMP:  smp_nx = wdata[i];
                    SEL_DSET: drv_nx = drv_q[i] | wdata[i];
                    SEL_DCLR: drv_nx = drv_q[i] & ~wdata[i];
                    SEL_IN, SEL_NONE: ;
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q[i] <= 1'b0;
                drv_q[i] <= 1'b0;
                smp_q[i] <= 1'b0;
            end else begin
                out_q[i] <= out_nx;
                drv_q[i] <= drv_nx;
                smp_q[i] <= smp_nx;
            end
        end
    end

    // R4: the set alias ORs the write data into the drive enables
    p_set_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DSET) |=> (drv_q == ($past(drv_q) | $past(wdata))));

    // R5: the clear alias removes only the selected drive enables
    p_clr_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DCLR) |=> (drv_q == ($past(drv_q) & ~$past(wdata))));

    // R8: writes to the input register or unmapped addresses change nothing
    p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_NONE || sel == SEL_IN))
        |=> ($stable(out_q) && $stable(drv_q) && $stable(smp_q)));

endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] smp_en,
    output logic [NPINS-1:0] in_val
);

    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chain <= '0;
            else if (!smp_en[i])
                chain <= '0;
            else
                chain <= {chain[STAGES-2:0], pad_in[i]};
        end

        assign in_val[i] = chain[LAST] & smp_en[i];
    end

    // R7: a disabled pin never shows a sampled 1
    p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_val & ~smp_en) == '0));

endmodule

// File: rtl/gpb_rdmux.sv
module gpb_rdmux
    import gpb_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [NPINS-1:0] in_val,
    input  logic [NPINS-1:0] out_q,
    input  logic [NPINS-1:0] drv_q,
    input  logic [NPINS-1:0] smp_q,
    output logic [NPINS-1:0] rdata
);

    logic [NPINS-1:0] rd_nx;

    always_comb begin
        unique case (sel)
            SEL_IN:  rd_nx = in_val;
            SEL_OUT: rd_nx = out_q;
            SEL_DRV: rd_nx = drv_q;
            SEL_SMP: rd_nx = smp_q;
            SEL_DSET, SEL_DCLR, SEL_NONE: rd_nx = '0;
            default: rd_nx = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_nx;
    end

    // R8: write-only aliases and unmapped addresses read as zero
    p_wo_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == SEL_NONE || sel == SEL_DSET || sel == SEL_DCLR))
        |=> (rdata == '0));

    // R7: input reads carry no bit whose sample enable was low
    p_in_read_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_IN) |=> ((rdata & ~$past(smp_q)) == '0));

    // R9: read data holds between reads
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpb_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_DRV  = ADDR_W'(OFS_DRV);
    localparam logic [ADDR_W-1:0] A_SMP  = ADDR_W'(OFS_SMP);
    localparam logic [ADDR_W-1:0] A_DSET = ADDR_W'(OFS_DSET);
    localparam logic [ADDR_W-1:0] A_DCLR = ADDR_W'(OFS_DCLR);

    reg_sel_e         sel;
    logic [NPINS-1:0] out_q, drv_q, smp_q, in_val;

    always_comb begin
        if      (bus_addr == A_IN)   sel = SEL_IN;
        else if (bus_addr == A_OUT)  sel = SEL_OUT;
        else if (bus_addr == A_DRV)  sel = SEL_DRV;
        else if (bus_addr == A_SMP)  sel = SEL_SMP;
        else if (bus_addr == A_DSET) sel = SEL_DSET;
        else if (bus_addr == A_DCLR) sel = SEL_DCLR;
        else                         sel = SEL_NONE;
    end

    gpb_regs #(.NPINS(NPINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .out_q (out_q),
        .drv_q (drv_q),
        .smp_q (smp_q)
    );

    gpb_sync #(.NPINS(NPINS), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .smp_en (smp_q),
        .in_val (in_val)
    );

    gpb_rdmux #(.NPINS(NPINS)) u_rdmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (bus_rd),
        .sel    (sel),
        .in_val (in_val),
        .out_q  (out_q),
        .drv_q  (drv_q),
        .smp_q  (smp_q),
        .rdata  (bus_rdata)
    );

    assign pad_oe  = drv_q;
    assign pad_out = out_q & drv_q;

    // R3: a plain drive-enable write lands on the pads at the next edge
    p_drive_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DRV) |=> (pad_oe == $past(bus_wdata)));

    // R2: undriven pads never carry a 1
    p_undriven_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_out = '0, m_drv = '0, m_smp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h0C: m_out = d;
            8'h10: m_drv = d;
            8'h58: m_smp = d;
            8'h70: m_drv = m_drv | d;
            8'h74: m_drv = m_drv & ~d;
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h04: return pad_in & m_smp;
            8'h0C: return m_out;
            8'h10: return m_drv;
            8'h58: return m_smp;
            default: return 32'h0;
        endcase
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_reg(input string req, input logic [7:0] a);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, model_read(a));
    endtask

    task automatic check_pads(input string req);
        check({req, " pad_oe"}, pad_oe, m_drv);
        check({req, " pad_out"}, pad_out, m_out & m_drv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the pads and on every readable register
        check_pads("R1");
        check_reg("R1 out", 8'h0C);
        check_reg("R1 drv", 8'h10);
        check_reg("R1 smp", 8'h58);
        check_reg("R1 in", 8'h04);

        // R4: walking set over every pin, read back in the next cycle
        for (int i = 0; i < 32; i++) begin
            bus_write(8'h70, 32'h1 << i);
            check_reg("R4 set walk", 8'h10);
        end
        check_pads("R4 all driven");

        // R5: walking clear over every pin
        for (int i = 0; i < 32; i += 2) begin
            bus_write(8'h74, 32'h1 << i);
            check_reg("R5 clear walk", 8'h10);
        end
        check_pads("R5 odd pins driven");

        // R2 R3: output patterns against partial drive enables
        for (int p = 0; p < 8; p++) begin
            logic [31:0] v;
            v = 32'hA5C3_0F96 ^ (32'h1111_1111 * p);
            bus_write(8'h0C, v);
            check_reg("R2 out readback", 8'h0C);
            bus_write(8'h10, ~v ^ (32'h0101_0101 << p));
            check_pads("R2 R3 pads");
            check_reg("R3 drv readback", 8'h10);
        end

        // R4 R5: multi-bit set/clear leaves other bits alone
        bus_write(8'h10, 32'hFF00_FF00);
        bus_write(8'h70, 32'h0F0F_0F0F);
        check_reg("R4 multi set", 8'h10);
        bus_write(8'h74, 32'h3333_0000);
        check_reg("R5 multi clear", 8'h10);
        bus_write(8'h70, 32'h0);
        check_reg("R4 zero set no change", 8'h10);
        bus_write(8'h74, 32'h0);
        check_reg("R5 zero clear no change", 8'h10);

        // R6: pad sampling through the synchroniser
        bus_write(8'h58, 32'hFFFF_FFFF);
        for (int p = 0; p < 6; p++) begin
            @(negedge clk);
            pad_in = 32'h1357_9BDF << p | (32'h8000_0001 >> p);
            repeat (3) @(negedge clk);
            check_reg("R6 sampled", 8'h04);
        end
        bus_write(8'h58, 32'h00FF_00FF);
        repeat (3) @(negedge clk);
        check_reg("R6 partial enable", 8'h04);

        // R7: clearing an enable blanks the bit in the very next read
        @(negedge clk);
        pad_in = 32'hFFFF_FFFF;
        bus_write(8'h58, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        check_reg("R7 full", 8'h04);
        bus_write(8'h58, 32'h0000_FFFF);
        check_reg("R7 immediate blank", 8'h04);
        bus_write(8'h58, 32'h0);
        check_reg("R7 all disabled", 8'h04);

        // R8: sweep every word address, write then read back all registers
        bus_write(8'h58, 32'h5A5A_5A5A);
        for (int a = 0; a < 256; a += 4) begin
            bus_write(8'(a), 32'hC3A5_5AC3 ^ 32'(a));
            bus_read(8'(a), d);
            check("R8 sweep read", d, model_read(8'(a)));
            check_reg("R8 out intact", 8'h0C);
            check_reg("R8 drv intact", 8'h10);
            check_reg("R8 smp intact", 8'h58);
        end
        bus_write(8'h0D, 32'hFFFF_FFFF);
        check_reg("R8 misaligned write", 8'h0C);
        bus_read(8'h11, d);
        check("R8 misaligned read", d, 32'h0);

        // R9: read data holds between reads; read with write returns old value
        bus_write(8'h0C, 32'h1234_5678);
        check_reg("R9 setup", 8'h0C);
        repeat (4) @(negedge clk);
        check("R9 hold", bus_rdata, 32'h1234_5678);
        @(negedge clk);
        bus_addr = 8'h0C; bus_wdata = 32'hDEAD_BEEF; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R9 read-before-write", bus_rdata, 32'h1234_5678);
        model_write(8'h0C, 32'hDEAD_BEEF);
        check_reg("R9 write landed", 8'h0C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule